// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This unit moves bits between the scattered set positions of a mask and a packed field at the bottom of a word. A gather (extract) request collects the source bits found at the mask's set positions and packs them, lowest position first, into the least significant bits of the result. A scatter (deposit) request does the reverse. It takes the low bits of the source in turn and places them at the mask's set positions, lowest first.

A request is presented on a single cycle with `in_valid` high. It carries an operation select, a width select (narrow half-word or full word), a source and a mask. The result is registered and appears on the next clock edge, with `out_valid` high for exactly that cycle. In narrow mode only the low half of the source and the low half of the mask take part. The upper half of the result is then zero.

Top module: `pbx_unit`

## Requirements
- R1: A gather (`in_op`=0) returns the source bits at the mask's set positions, in ascending position order, packed into result bits 0 upward. Every result bit at or above the mask's population count is zero.
- R2: A scatter (`in_op`=1) places source bit k at the position of the k-th lowest set bit of the mask, counting k from 0. Every result bit where the mask is zero is zero.
- R3: With `in_wide`=0, only bits [31:0] of `in_src` and `in_mask` are used, and result bits [63:32] are zero. With `in_wide`=1, all 64 bits are used.
- R4: A request accepted at a clock edge makes `out_valid` high for the following cycle only, with its result on `out_result`. When no request is accepted, `out_valid` is low and `out_result` holds its previous value.
- R5: A mask that is zero over the active width gives a zero result for both operations.
- R6: With an all-ones source, a gather returns a run of ones whose length is the mask's population count, and a scatter returns the mask itself. For example, a 64-bit mask with 9 set bits gathers to 511.
- R7: A scatter applied to the result of a gather with the same mask and width returns the source ANDed with the mask.
- R8: After a synchronous active-high reset, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| in_op | input | 1 | 0 = gather, 1 = scatter |
| in_src | input | 64 | Source operand |
| in_mask | input | 64 | Selection mask |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Registered result |

## Verification
The bench builds the unit at its default 64-bit word. This makes the narrow mode the 32-bit half, so one build covers both width selects. It also covers the truncation of stray upper source and mask bits in narrow mode. Known vectors, all-ones sources, and full, empty and single-bit masks reach the edges of the rank range: a rank of 0 and a rank of 63. Seeded random gather/scatter pairs test the round-trip identity at both widths. Idle cycles between requests show that the result holds.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    localparam int unsigned PBX_W  = 64;
    localparam int unsigned PBX_NW = PBX_W / 2;

    typedef enum logic {
        OP_GATHER  = 1'b0,
        OP_SCATTER = 1'b1
    } pbx_op_e;

    typedef logic [PBX_W-1:0] pbx_word_t;

    typedef struct packed {
        pbx_op_e   op;
        logic      wide;
        pbx_word_t src;
        pbx_word_t mask;
    } pbx_req_t;

    // Keep only the active width of an operand.
    function automatic pbx_word_t pbx_trim(input logic wide, input pbx_word_t v);
        pbx_word_t r;
        r = v;
        if (!wide) begin
            r[PBX_W-1:PBX_NW] = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/pbx_rank.sv
// Prefix population count: rank[i] = number of set mask bits below position i.
module pbx_rank #(
    parameter int unsigned W  = 64,
    localparam int unsigned RW = $clog2(W + 1)
) (
    input  logic [W-1:0]          mask,
    output logic [W-1:0][RW-1:0]  rank,
    output logic [RW-1:0]         total
);
    logic [W:0][RW-1:0] chain;

    assign chain[0] = '0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_prefix
            assign chain[i+1] = chain[i] + {{(RW-1){1'b0}}, mask[i]};
            assign rank[i]    = chain[i];
        end
    endgenerate

    assign total = chain[W];
endmodule

// File: rtl/pbx_gather.sv
module pbx_gather #(
    parameter int unsigned W  = 64,
    localparam int unsigned RW = $clog2(W + 1),
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]          src,
    input  logic [W-1:0]          mask,
    input  logic [W-1:0][RW-1:0]  rank,
    input  logic [RW-1:0]         total,
    output logic [W-1:0]          result
);
    always_comb begin
        result = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                result[rank[i][IW-1:0]] = src[i];
            end
        end
    end

    // Nothing may land at or above the count of selected bits.
    always_comb begin
        if (total < RW'(W)) begin
            assert_gather_packed_R1: assert ((result >> total) == '0);
        end
    end
endmodule

// File: rtl/pbx_scatter.sv
module pbx_scatter #(
    parameter int unsigned W  = 64,
    localparam int unsigned RW = $clog2(W + 1),
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]          src,
    input  logic [W-1:0]          mask,
    input  logic [W-1:0][RW-1:0]  rank,
    output logic [W-1:0]          result
);
    always_comb begin
        result = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                result[i] = src[rank[i][IW-1:0]];
            end
        end
    end
endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
    import pbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic              in_op,
    input  logic [PBX_W-1:0]  in_src,
    input  logic [PBX_W-1:0]  in_mask,
    output logic              out_valid,
    output logic [PBX_W-1:0]  out_result
);
    localparam int unsigned RW = $clog2(PBX_W + 1);

    pbx_req_t req;
    pbx_word_t gather_res, scatter_res, next_res;
    logic [PBX_W-1:0][RW-1:0] rank;
    logic [RW-1:0] total;

    always_comb begin
        req.op   = pbx_op_e'(in_op);
        req.wide = in_wide;
        req.src  = pbx_trim(in_wide, in_src);
        req.mask = pbx_trim(in_wide, in_mask);
    end

    pbx_rank #(.W(PBX_W)) u_rank (
        .mask  (req.mask),
        .rank  (rank),
        .total (total)
    );

    pbx_gather #(.W(PBX_W)) u_gather (
        .src    (req.src),
        .mask   (req.mask),
        .rank   (rank),
        .total  (total),
        .result (gather_res)
    );

    pbx_scatter #(.W(PBX_W)) u_scatter (
        .src    (req.src),
        .mask   (req.mask),
        .rank   (rank),
        .result (scatter_res)
    );

    assign next_res = (req.op == OP_SCATTER) ? scatter_res : gather_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= next_res;
            end
        end
    end

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide) |=> (out_result[PBX_W-1:PBX_NW] == '0));
    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mask[PBX_NW-1:0] == '0) && (!in_wide || in_mask[PBX_W-1:PBX_NW] == '0))
        |=> (out_result == '0));
    assert_scatter_in_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && in_wide) |=> ((out_result & ~$past(in_mask)) == '0));
endmodule

// File: tb/tb_pbx_unit.sv
module tb_pbx_unit;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_wide = 1'b0;
    logic in_op = 1'b0;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_mask = '0;
    logic out_valid;
    logic [W-1:0] out_result;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pbx_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
        .in_op(in_op), .in_src(in_src), .in_mask(in_mask),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [W-1:0] trim(input logic wide, input logic [W-1:0] v);
        return wide ? v : {32'h0, v[31:0]};
    endfunction

    function automatic logic [W-1:0] ref_gather(input logic wide, input logic [W-1:0] s,
                                                input logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        logic [W-1:0] ss = trim(wide, s);
        logic [W-1:0] mm = trim(wide, m);
        for (int i = 0; i < W; i++) begin
            if (mm[i]) begin
                r[k] = ss[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_scatter(input logic wide, input logic [W-1:0] s,
                                                 input logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        logic [W-1:0] ss = trim(wide, s);
        logic [W-1:0] mm = trim(wide, m);
        for (int i = 0; i < W; i++) begin
            if (mm[i]) begin
                r[i] = ss[k];
                k++;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request at a negedge, sample at the next negedge.
    task automatic run(input string tag, input logic op, input logic wide,
                       input logic [W-1:0] s, input logic [W-1:0] m,
                       input logic [W-1:0] exp, output logic [W-1:0] got);
        in_valid = 1'b1; in_op = op; in_wide = wide; in_src = s; in_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R4 valid"}, {63'h0, out_valid}, 64'h1);
        check(tag, out_result, exp);
        got = out_result;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] got, g2, held;
        logic [W-1:0] ehlo = 64'h202020204F4C4845;
        logic [W-1:0] msk  = 64'hA080800302020001;
        int unsigned seed;
        seed = $urandom(32'h5EED1234);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset valid", {63'h0, out_valid}, 64'h0);
        check("R8 reset result", out_result, 64'h0);

        run("R1 gather 64 known", 1'b0, 1'b1, ehlo, msk, 64'd133, got);
        run("R7 scatter of gather", 1'b1, 1'b1, got, msk, ehlo & msk, got);
        run("R3 gather 32 known", 1'b0, 1'b0, ehlo, msk, 64'd5, got);
        run("R6 gather ones 64", 1'b0, 1'b1, '1, msk, 64'd511, got);
        run("R6 R3 gather ones 32", 1'b0, 1'b0, '1, msk, 64'd7, got);
        run("R6 scatter ones 64", 1'b1, 1'b1, '1, msk, msk, got);
        run("R6 R3 scatter ones 32", 1'b1, 1'b0, '1, msk, 64'h02020001, got);
        run("R5 gather zero mask", 1'b0, 1'b1, '1, '0, '0, got);
        run("R5 scatter zero mask", 1'b1, 1'b1, '1, '0, '0, got);
        run("R5 R3 scatter upper-only mask narrow", 1'b1, 1'b0, '1, 64'hFFFF_FFFF_0000_0000, '0, got);
        run("R1 gather full mask", 1'b0, 1'b1, 64'hDEADBEEF01234567, '1, 64'hDEADBEEF01234567, got);
        run("R2 scatter full mask", 1'b1, 1'b1, 64'hDEADBEEF01234567, '1, 64'hDEADBEEF01234567, got);
        run("R1 gather top bit", 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h1, got);
        run("R2 scatter top bit", 1'b1, 1'b1, 64'h1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, got);
        run("R2 scatter ascending", 1'b1, 1'b1, 64'h5, 64'h0000_0F00_0000_0000, 64'h0000_0500_0000_0000, got);
        run("R3 scatter narrow ignores upper src", 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFF_0000_00F0, 64'h20, got);

        // Idle: valid drops and result holds.
        held = out_result;
        @(negedge clk);
        check("R4 idle valid", {63'h0, out_valid}, 64'h0);
        check("R4 idle hold", out_result, held);

        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] s = {$urandom, $urandom};
            logic [W-1:0] m = {$urandom, $urandom};
            logic wide = $urandom % 2;
            if (n % 7 == 0) m = m & {$urandom, $urandom};
            run("R1 random gather", 1'b0, wide, s, m, ref_gather(wide, s, m), got);
            run("R2 random scatter", 1'b1, wide, s, m, ref_scatter(wide, s, m), g2);
            run("R7 random round trip", 1'b1, wide, got, m, trim(wide, s) & trim(wide, m), g2);
            if (n % 5 == 0) begin
                held = out_result;
                @(negedge clk);
                check("R4 random idle hold", out_result, held);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule